// File: doc/BRIEF.md
# Bus Response Timeout Monitor

This block sits beside an internal request/acknowledge system bus and watches every transaction. A transaction opens when a master raises its request and stays open until the addressed target acknowledges. If no acknowledge arrives within a programmable number of bus clocks, the monitor drives an error response itself, so the stalled transfer completes and the system does not hang on an undecoded address or a broken target.

When a timeout occurs, the monitor records the failing address and reports the error according to who issued the access. A write issued by the main CPU sets a sticky status bit, which can raise an interrupt. A read issued by the main CPU is returned at once as a bus-error signal to the CPU. An access by any other master sets that master's own sticky error flag. Detection is turned on by a configuration bit. It is forced off while a debug probe is attached, so that halted debug sessions do not produce false errors.

Software reaches the block through a small word-wide configuration port with three registers: control, status and captured address.

Top module: `bus_timeout_mon`

## Requirements
- R1: With the enable bit (control register, offset 0, bit 0) clear, no transaction ever receives errResp, and no status bit or error flag is set.
- R2: With detection active and a limit L, a request first seen in cycle k that has no tgtAck gets errResp (one cycle) in cycle k+L, and that ends the transaction.
- R3: A tgtAck in any cycle from k to k+L, including cycle k+L itself, completes the transaction without errResp. Each new request restarts the count.
- R4: The limit field is control bits [15:8]. A field value of 0 means a limit of 256 cycles.
- R5: The captured-address register (offset 2) takes the bus address on a timeout only while the held flag (status offset 1, bit 1) is clear. The timeout sets that flag, which keeps the first failing address. Writing 1 to the flag clears it.
- R6: A timeout on a CPU write (master ID 0, busWrite=1) sets the write-error bit (status bit 0). The bit is sticky and is cleared by writing 1 to it. irqOut is that bit ANDed with the interrupt-enable bit (control bit 1).
- R7: A timeout on a CPU read (master ID 0, busWrite=0) drives cpuBusErr in the same cycle as errResp and does not set status bit 0.
- R8: A timeout on an access by master m≠0 sets masterErr[m], which is mirrored in status bit 16+m. The flag is sticky and is cleared by writing 1 to that status bit.
- R9: While probeAttached is high, detection is off and transactions behave as in R1.
- R10: After reset, all three registers read 0 and errResp, cpuBusErr, irqOut and masterErr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Register select: 0 control, 1 status, 2 captured address |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read data for cfgAddr |
| probeAttached | input | 1 | High while a debug probe is attached |
| busReq | input | 1 | Request active, held until acknowledge or error |
| busAddr | input | 32 | Address of the current request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busMaster | input | 2 | ID of the issuing master, 0 = main CPU |
| tgtAck | input | 1 | Target acknowledge |
| errResp | output | 1 | Forced error termination |
| cpuBusErr | output | 1 | Bus error returned to the CPU on a read timeout |
| masterErr | output | 4 | Sticky per-master error flags |
| irqOut | output | 1 | Write-error interrupt |

## Verification
The hardest case to reach is an acknowledge that lands in exactly the cycle the count expires, together with the default-zero field that stretches the window to 256 cycles. The driver task takes the acknowledge cycle as an argument and places it at L-1, L and L+1 cycles after the request's first cycle. A monitor counts the cycles the request is held and compares that count with the scoreboard entry. Preserving the first captured address is reached by running a second timeout without clearing the held flag, then reading the register back.

// File: rtl/btm_pkg.sv
package btm_pkg;
  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_STATUS = 2'd1;
  localparam logic [1:0] REG_CAPADR = 2'd2;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_IRQ_BIT   = 1;
  localparam int CTRL_LIM_LSB   = 8;
  localparam int STAT_WERR_BIT  = 0;
  localparam int STAT_HELD_BIT  = 1;
  localparam int STAT_MERR_LSB  = 16;

  typedef struct packed {
    logic fire;
    logic cpuWrite;
    logic cpuRead;
    logic otherMaster;
  } tmoStrobe_t;
endpackage

// File: rtl/btm_ctrl.sv
module btm_ctrl
  import btm_pkg::*;
#(
  parameter int TW = 8,
  parameter int MW = 2,
  parameter int CPU_ID = 0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgEnable,
  input  logic          probeAttached,
  input  logic [TW:0]   limitVal,
  input  logic          busReq,
  input  logic          busWrite,
  input  logic [MW-1:0] busMaster,
  input  logic          tgtAck,
  output tmoStrobe_t    strb,
  output logic          errResp,
  output logic          cpuBusErr
);
  logic        detEn;
  logic        busy;
  logic [TW:0] waitCnt;
  logic        fire;
  logic        isCpu;

  assign detEn = cfgEnable & ~probeAttached;
  assign isCpu = (busMaster == MW'(CPU_ID));
  // acknowledge in the expiry cycle wins over the timeout
  assign fire  = detEn & busy & busReq & ~tgtAck & (waitCnt == limitVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      waitCnt <= '0;
    end else if (!detEn) begin
      busy    <= 1'b0;
      waitCnt <= '0;
    end else if (busy) begin
      if (!busReq || tgtAck || fire) begin
        busy    <= 1'b0;
        waitCnt <= '0;
      end else begin
        waitCnt <= waitCnt + 1'b1;
      end
    end else if (busReq && !tgtAck) begin
      busy    <= 1'b1;
      waitCnt <= (TW+1)'(1);
    end
  end

  always_comb begin
    strb.fire        = fire;
    strb.cpuWrite    = fire & isCpu & busWrite;
    strb.cpuRead     = fire & isCpu & ~busWrite;
    strb.otherMaster = fire & ~isCpu;
  end

  assign errResp   = fire;
  assign cpuBusErr = strb.cpuRead;

  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> !errResp);
  p_err_needs_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    errResp |=> !busy);
  p_ack_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    tgtAck |-> !errResp);
  p_read_err_pairs_r7: assert property (@(posedge clk) disable iff (!rstN)
    cpuBusErr |-> (errResp && !busWrite));
  p_probe_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    probeAttached |-> !errResp);
endmodule

// File: rtl/btm_dpath.sv
module btm_dpath
  import btm_pkg::*;
#(
  parameter int TW = 8,
  parameter int AW = 32,
  parameter int NM = 4,
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [1:0]    cfgAddr,
  input  logic [31:0]   cfgWrData,
  output logic [31:0]   cfgRdData,
  input  logic [AW-1:0] busAddr,
  input  logic [MW-1:0] busMaster,
  input  tmoStrobe_t    strb,
  output logic          cfgEnable,
  output logic [TW:0]   limitVal,
  output logic [NM-1:0] masterErr,
  output logic          irqOut
);
  logic          irqEn;
  logic [TW-1:0] limField;
  logic          wrErr;
  logic          addrHeld;
  logic [NM-1:0] mErrQ;
  logic [AW-1:0] capAddr;
  logic          ctrlWr;
  logic          statWr;
  logic [NM-1:0] mSet;
  logic          unusedWd;

  assign ctrlWr   = cfgWrEn && (cfgAddr == REG_CTRL);
  assign statWr   = cfgWrEn && (cfgAddr == REG_STATUS);
  assign limitVal = (limField == '0) ? ((TW+1)'(1) << TW) : {1'b0, limField};
  assign mSet     = strb.otherMaster ? (NM'(1) << busMaster) : '0;
  assign unusedWd = &{1'b0, cfgWrData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEnable <= 1'b0;
      irqEn     <= 1'b0;
      limField  <= '0;
    end else if (ctrlWr) begin
      cfgEnable <= cfgWrData[CTRL_EN_BIT];
      irqEn     <= cfgWrData[CTRL_IRQ_BIT];
      limField  <= cfgWrData[CTRL_LIM_LSB +: TW];
    end
  end

  // sticky status, write-one-to-clear, a new event beats the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrErr    <= 1'b0;
      addrHeld <= 1'b0;
      mErrQ    <= '0;
    end else begin
      wrErr    <= (wrErr & ~(statWr & cfgWrData[STAT_WERR_BIT])) | strb.cpuWrite;
      addrHeld <= (addrHeld & ~(statWr & cfgWrData[STAT_HELD_BIT])) | strb.fire;
      mErrQ    <= (mErrQ & ~(statWr ? cfgWrData[STAT_MERR_LSB +: NM] : '0)) | mSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      capAddr <= '0;
    else if (strb.fire && !addrHeld) capAddr <= busAddr;
  end

  always_comb begin
    cfgRdData = '0;
    case (cfgAddr)
      REG_CTRL: begin
        cfgRdData[CTRL_EN_BIT]             = cfgEnable;
        cfgRdData[CTRL_IRQ_BIT]            = irqEn;
        cfgRdData[CTRL_LIM_LSB +: TW]      = limField;
      end
      REG_STATUS: begin
        cfgRdData[STAT_WERR_BIT]           = wrErr;
        cfgRdData[STAT_HELD_BIT]           = addrHeld;
        cfgRdData[STAT_MERR_LSB +: NM]     = mErrQ;
      end
      REG_CAPADR: cfgRdData = 32'(capAddr);
      default:    cfgRdData = '0;
    endcase
  end

  assign masterErr = mErrQ;
  assign irqOut    = wrErr & irqEn;

  p_addr_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(addrHeld) |-> $stable(capAddr));
  p_wrerr_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrErr) |-> $past(strb.cpuWrite));
  p_merr_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|(mErrQ & ~$past(mErrQ))) |-> $past(strb.otherMaster));
endmodule

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon
  import btm_pkg::*;
#(
  parameter int TW = 8,
  parameter int AW = 32,
  parameter int NM = 4,
  parameter int CPU_ID = 0,
  localparam int MW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [1:0]    cfgAddr,
  input  logic [31:0]   cfgWrData,
  output logic [31:0]   cfgRdData,
  input  logic          probeAttached,
  input  logic          busReq,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrite,
  input  logic [MW-1:0] busMaster,
  input  logic          tgtAck,
  output logic          errResp,
  output logic          cpuBusErr,
  output logic [NM-1:0] masterErr,
  output logic          irqOut
);
  tmoStrobe_t  strb;
  logic        cfgEnable;
  logic [TW:0] limitVal;

  btm_ctrl #(.TW(TW), .MW(MW), .CPU_ID(CPU_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .probeAttached(probeAttached),
    .limitVal(limitVal), .busReq(busReq), .busWrite(busWrite), .busMaster(busMaster),
    .tgtAck(tgtAck), .strb(strb), .errResp(errResp), .cpuBusErr(cpuBusErr)
  );

  btm_dpath #(.TW(TW), .AW(AW), .NM(NM), .MW(MW)) u_dpath (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .busAddr(busAddr), .busMaster(busMaster), .strb(strb),
    .cfgEnable(cfgEnable), .limitVal(limitVal), .masterErr(masterErr), .irqOut(irqOut)
  );
endmodule

// File: tb/bus_timeout_mon_tb.sv
module bus_timeout_mon_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        cfgWrEn = 0;
  logic [1:0]  cfgAddr = 0;
  logic [31:0] cfgWrData = 0;
  logic [31:0] cfgRdData;
  logic        probeAttached = 0;
  logic        busReq = 0;
  logic [31:0] busAddr = 0;
  logic        busWrite = 0;
  logic [1:0]  busMaster = 0;
  logic        tgtAck = 0;
  logic        errResp, cpuBusErr, irqOut;
  logic [3:0]  masterErr;

  int nChecks = 0;
  int nErrors = 0;
  int monCyc = 0;

  typedef struct {
    logic [31:0] addr;
    bit          err;
    bit          cpuErr;
    int          cycles;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  bus_timeout_mon u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .probeAttached(probeAttached), .busReq(busReq),
    .busAddr(busAddr), .busWrite(busWrite), .busMaster(busMaster), .tgtAck(tgtAck),
    .errResp(errResp), .cpuBusErr(cpuBusErr), .masterErr(masterErr), .irqOut(irqOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 0; cfgWrData = 0;
  endtask

  task automatic cfgCheck(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfgAddr = a;
    #1 chk(cfgRdData == exp, tag, cfgRdData, exp);
  endtask

  // driver: computes expectation from the requirements, pushes it, then drives
  task automatic runTxn(input logic [31:0] a, input logic [1:0] m, input bit w,
                        input int ackAt, input bit active, input int lim, input string tag);
    exp_t e;
    int i;
    e.addr = a; e.tag = tag;
    if (!active || (ackAt >= 0 && ackAt <= lim)) begin
      e.err = 0; e.cycles = ackAt + 1;
    end else begin
      e.err = 1; e.cycles = lim + 1;
    end
    e.cpuErr = e.err && (m == 0) && !w;
    expQ.push_back(e);
    @(negedge clk);
    busReq = 1; busAddr = a; busMaster = m; busWrite = w; tgtAck = (ackAt == 0);
    i = 0;
    forever begin
      #3;
      if (errResp || tgtAck || i > 600) break;
      @(negedge clk);
      i++;
      tgtAck = (i == ackAt);
    end
    @(negedge clk);
    busReq = 0; tgtAck = 0;
  endtask

  // monitor: counts held cycles, pops and compares at each termination
  always begin
    @(negedge clk);
    #2;
    if (rstN && busReq) begin
      monCyc++;
      if (tgtAck || errResp) begin
        if (expQ.size() == 0) begin
          chk(0, "scoreboard underflow", 0, 1);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk(errResp == e.err, {e.tag, " errResp"}, errResp, e.err);
          chk(cpuBusErr == e.cpuErr, {e.tag, " cpuBusErr"}, cpuBusErr, e.cpuErr);
          chk(monCyc == e.cycles, {e.tag, " cycles"}, monCyc, e.cycles);
          chk(busAddr == e.addr, {e.tag, " addr"}, busAddr, e.addr);
        end
        monCyc = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10 reset state
    cfgCheck(2'd0, 32'h0, "R10 ctrl after reset");
    cfgCheck(2'd1, 32'h0, "R10 status after reset");
    cfgCheck(2'd2, 32'h0, "R10 capaddr after reset");
    chk({errResp, cpuBusErr, irqOut, masterErr} == 7'h0, "R10 outputs after reset",
        {errResp, cpuBusErr, irqOut, masterErr}, 0);

    // R1 disabled: limit 4 but enable clear
    cfgWrite(2'd0, 32'h0000_0400);
    runTxn(32'h1000_0000, 2'd0, 1'b0, 9, 1'b0, 4, "R1 disabled");
    cfgCheck(2'd1, 32'h0, "R1 status untouched");

    // R2 / R6 CPU write timeout, limit 4
    cfgWrite(2'd0, 32'h0000_0401);
    runTxn(32'hA000_0010, 2'd0, 1'b1, -1, 1'b1, 4, "R2 cpu write timeout");
    cfgCheck(2'd1, 32'h3, "R6 write error and held flag");
    cfgCheck(2'd2, 32'hA000_0010, "R5 first address captured");
    chk(irqOut == 0, "R6 irq masked", irqOut, 0);
    cfgWrite(2'd0, 32'h0000_0403);
    #1 chk(irqOut == 1, "R6 irq enabled", irqOut, 1);

    // R5 second timeout keeps first address
    runTxn(32'hB000_0020, 2'd0, 1'b1, -1, 1'b1, 4, "R5 second timeout");
    cfgCheck(2'd2, 32'hA000_0010, "R5 address preserved");

    // R3 acknowledge at limit, before limit
    runTxn(32'h2000_0000, 2'd0, 1'b1, 4, 1'b1, 4, "R3 ack at expiry");
    runTxn(32'h2000_0004, 2'd1, 1'b0, 3, 1'b1, 4, "R3 ack early");
    runTxn(32'h2000_0008, 2'd1, 1'b0, 5, 1'b1, 4, "R3 ack one late");
    chk(masterErr == 4'b0010, "R8 master 1 flag", masterErr, 4'b0010);

    // clear status W1C
    cfgWrite(2'd1, 32'h000F_0003);
    cfgCheck(2'd1, 32'h0, "R5 R6 R8 status cleared");
    #1 chk(irqOut == 0, "R6 irq drops after clear", irqOut, 0);

    // R7 CPU read
    runTxn(32'hC000_0040, 2'd0, 1'b0, -1, 1'b1, 4, "R7 cpu read timeout");
    cfgCheck(2'd1, 32'h2, "R7 no write error bit");
    cfgCheck(2'd2, 32'hC000_0040, "R5 capture after clear");

    // R8 master 2 write
    runTxn(32'hD000_0080, 2'd2, 1'b1, -1, 1'b1, 4, "R8 master 2 timeout");
    chk(masterErr == 4'b0100, "R8 master 2 flag", masterErr, 4'b0100);
    cfgCheck(2'd1, 32'h0004_0002, "R8 status mirror");
    cfgWrite(2'd1, 32'h0004_0000);
    #1 chk(masterErr == 4'b0000, "R8 flag cleared", masterErr, 0);

    // R9 probe attached
    probeAttached = 1;
    runTxn(32'hE000_0000, 2'd3, 1'b0, 9, 1'b0, 4, "R9 probe attached");
    chk(masterErr == 4'b0000, "R9 no flag", masterErr, 0);
    probeAttached = 0;

    // R4 zero field means 256
    cfgWrite(2'd0, 32'h0000_0001);
    runTxn(32'hF000_0000, 2'd3, 1'b1, 200, 1'b1, 256, "R4 ack within 256");
    runTxn(32'hF000_0004, 2'd3, 1'b1, -1, 1'b1, 256, "R4 timeout at 256");
    chk(masterErr == 4'b1000, "R4 master 3 flag", masterErr, 4'b1000);

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule